// File: doc/BRIEF.md
# Transmit Buffer Egress Byte Aligner

This block sits on the read side of a transmit buffer. Each buffer element arrives as a run of 64-bit big-endian words: a header that was written in whole 8-byte chunks, then payload from another source. Because the header was written on chunk boundaries, up to seven bytes at the front of the element carry nothing. The aligner throws those bytes away and packs everything after them into a gap-free stream of 64-bit beats for the egress side.

A control word is given together with the first data word of each element. It holds a start offset, which is the number of leading bytes to drop, and a length, which is the count of bytes to deliver after the dropped ones. The aligner keeps up to 15 bytes in a holding register and merges the remainder of one input word with the next. Only the closing beat of an element may be partly filled. Both sides use valid/ready handshakes, and backpressure on the output holds the input back without losing any byte.

Top module: `tx_byte_aligner`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: On the first word of an element, the leading `ctl_skip` byte lanes are dropped. Byte lane 0 is bits 63:56 and holds the lowest address. The first output byte is lane `ctl_skip` of that word.
- R3: Every beat other than the closing one carries `out_bytes` = 8 with `out_last` = 0.
- R4: The closing beat has `out_last` = 1 and `out_bytes` equal to the bytes left (1 to 8). Those bytes are left-justified from bits 63:56 and every unused lane is zero.
- R5: The bytes delivered for an element are exactly `ctl_len` bytes, in input order, with no gaps.
- R6: With `ctl_skip` = 0, each full output beat equals the corresponding input word.
- R7: When `ctl_skip + ctl_len` <= 8, the element produces exactly one beat.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_bytes` and `out_last` stay unchanged. No byte is lost or repeated.
- R9: `ctl_skip` and `ctl_len` are sampled only with the first word of an element. Their values on later words have no effect on the output.
- R10: The element consumes ceil((`ctl_skip` + `ctl_len`)/8) input words. Once its closing beat is taken, the block returns to `out_valid` = 0 and `in_ready` = 1, ready for the next first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Aligner accepts the input word this cycle |
| in_data | input | 64 | Buffer word, big-endian byte lanes |
| ctl_skip | input | 3 | Leading bytes to drop; sampled with the first word only |
| ctl_len | input | LEN_W | Bytes to deliver after the skipped ones (at least 1); sampled with the first word only |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Egress side takes the beat |
| out_data | output | 64 | Packed beat, left-justified |
| out_bytes | output | 4 | Valid bytes in the beat (1 to 8) |
| out_last | output | 1 | Closing beat of the element |

## Verification
The hardest case to reach is a full holding register that must merge a new word in the same cycle a beat is popped. This needs a non-zero offset, a pending full beat and output backpressure that releases exactly when the next input word is waiting. The stimulus reaches it by running elements with unaligned offsets while `out_ready` alternates or opens only every third cycle. The bench changes the control inputs on every non-first word and checks that each delivered byte matches the expected sequence and that stalled beats hold still.

// File: rtl/txa_pkg.sv
package txa_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int HOLD_W     = 2 * BEAT_W;
    localparam int FILL_W     = 5;
    localparam int TAKE_W     = 4;
endpackage

// File: rtl/txa_word_extract.sv
// Drops the leading lanes of a word and keeps only the first take bytes.
module txa_word_extract
    import txa_pkg::*;
(
    input  logic [BEAT_W-1:0] word_i,
    input  logic [2:0]        skip_i,
    input  logic [TAKE_W-1:0] take_i,
    output logic [BEAT_W-1:0] word_o
);
    logic [BEAT_W-1:0] shifted;
    logic [BEAT_W-1:0] keep_mask;

    always_comb begin
        shifted = word_i << {skip_i, 3'b000};
        if (take_i >= TAKE_W'(BEAT_BYTES))
            keep_mask = '1;
        else
            keep_mask = ~({BEAT_W{1'b1}} >> {take_i, 3'b000});
        word_o = shifted & keep_mask;
    end
endmodule

// File: rtl/txa_hold_merge.sv
// Pops a beat from the holding register, then appends fresh bytes after the residue.
module txa_hold_merge
    import txa_pkg::*;
(
    input  logic [HOLD_W-1:0] hold_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic              pop_i,
    input  logic              push_i,
    input  logic [BEAT_W-1:0] word_i,
    input  logic [TAKE_W-1:0] take_i,
    output logic [HOLD_W-1:0] hold_o,
    output logic [FILL_W-1:0] fill_o
);
    logic [HOLD_W-1:0] base;
    logic [FILL_W-1:0] fill_b;

    always_comb begin
        base   = hold_i;
        fill_b = fill_i;
        if (pop_i) begin
            base   = hold_i << BEAT_W;
            fill_b = (fill_i > FILL_W'(BEAT_BYTES)) ? fill_i - FILL_W'(BEAT_BYTES) : '0;
        end
        hold_o = base;
        fill_o = fill_b;
        if (push_i) begin
            hold_o = base | ({word_i, {BEAT_W{1'b0}}} >> {fill_b, 3'b000});
            fill_o = fill_b + FILL_W'(take_i);
        end
    end
endmodule

// File: rtl/tx_byte_aligner.sv
module tx_byte_aligner
    import txa_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_data,
    input  logic [2:0]        ctl_skip,
    input  logic [LEN_W-1:0]  ctl_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_data,
    output logic [3:0]        out_bytes,
    output logic              out_last
);
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [FILL_W-1:0] fill;
        logic [LEN_W-1:0]  absorb;
    } aln_state_t;

    aln_state_t st_q, st_d;

    logic              idle, pop, push;
    logic [2:0]        skip_eff;
    logic [TAKE_W-1:0] avail, take;
    logic [LEN_W-1:0]  need;
    logic [BEAT_W-1:0] picked;
    logic [HOLD_W-1:0] hold_n;
    logic [FILL_W-1:0] fill_n;

    txa_word_extract u_extract (
        .word_i (in_data),
        .skip_i (skip_eff),
        .take_i (take),
        .word_o (picked)
    );

    txa_hold_merge u_merge (
        .hold_i (st_q.hold),
        .fill_i (st_q.fill),
        .pop_i  (pop),
        .push_i (push),
        .word_i (picked),
        .take_i (take),
        .hold_o (hold_n),
        .fill_o (fill_n)
    );

    always_comb begin
        idle      = (st_q.absorb == '0) && (st_q.fill == '0);
        out_valid = (st_q.fill >= FILL_W'(BEAT_BYTES)) ||
                    ((st_q.absorb == '0) && (st_q.fill != '0));
        out_last  = (st_q.absorb == '0) && (st_q.fill <= FILL_W'(BEAT_BYTES));
        out_bytes = (st_q.fill >= FILL_W'(BEAT_BYTES)) ? 4'd8 : st_q.fill[3:0];
        out_data  = st_q.hold[HOLD_W-1 -: BEAT_W];
        pop       = out_valid && out_ready;
        in_ready  = idle ||
                    ((st_q.absorb != '0) && ((st_q.fill < FILL_W'(BEAT_BYTES)) || pop));
        push      = in_valid && in_ready;

        skip_eff  = idle ? ctl_skip : 3'd0;
        avail     = TAKE_W'(BEAT_BYTES) - TAKE_W'(skip_eff);
        need      = idle ? ctl_len : st_q.absorb;
        take      = (need < LEN_W'(avail)) ? need[TAKE_W-1:0] : avail;

        st_d        = st_q;
        st_d.hold   = hold_n;
        st_d.fill   = fill_n;
        if (push)
            st_d.absorb = need - LEN_W'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Non-closing beats are always full.
    assert_full_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> out_bytes == 4'd8);

    // Closing beat count in range and unused lanes cleared.
    assert_last_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> (out_bytes >= 4'd1) && (out_bytes <= 4'd8));
    assert_last_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> (out_data << {out_bytes, 3'b000}) == 64'd0);

    // A stalled beat holds still.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                    $stable(out_bytes) && $stable(out_last));

    // No room while a full beat waits and is not taken.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !out_last |-> !in_ready);

    // After the closing beat leaves, the block is idle again.
    assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready);
endmodule

// File: tb/tx_byte_aligner_tb_top.sv
module tx_byte_aligner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [2:0]  ctl_skip = '0;
    logic [15:0] ctl_len = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic [3:0]  out_bytes;
    logic        out_last;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [7:0]  exp_b [0:63];
    logic [7:0]  got_b [0:63];
    logic [63:0] words [0:9];
    int          nwords;
    int          ngot;
    int          nbeats;
    int          bp_mode;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tx_byte_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .ctl_skip(ctl_skip), .ctl_len(ctl_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_bytes(out_bytes), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic t_reset();
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_words(input int skip, input int len);
        for (int w = 0; w < nwords; w++) begin
            bit ok;
            ok = 1'b0;
            while (!ok) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = words[w];
                // later words carry misleading control values (R9)
                ctl_skip = (w == 0) ? 3'(skip) : 3'd5;
                ctl_len  = (w == 0) ? 16'(len) : 16'd3;
                #2;
                ok = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect(input int skip, input int len);
        bit          stalled;
        logic [63:0] held;
        bit          fin;
        stalled = 1'b0; held = '0; fin = 1'b0;
        ngot = 0; nbeats = 0;
        while (!fin) begin
            @(negedge clk);
            case (bp_mode)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                default: out_ready = (cyc % 3) == 0;
            endcase
            #2;
            if (stalled)
                check(out_valid && out_data == held, "R8", "stalled beat changed",
                      out_data, held);
            stalled = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                if (!out_last) begin
                    check(out_bytes == 4'd8, "R3", "non-closing beat count", out_bytes, 8);
                end else begin
                    check(32'(out_bytes) == len - ngot, "R4", "closing beat count",
                          out_bytes, len - ngot);
                    check((out_data << (8 * out_bytes)) == 64'd0, "R4",
                          "unused lanes not zero", out_data, 0);
                    fin = 1'b1;
                end
                if (skip == 0 && nbeats == 0 && len >= 8)
                    check(out_data == words[0], "R6", "pass-through beat", out_data, words[0]);
                for (int b = 0; b < 32'(out_bytes); b++)
                    if (ngot + b < 64) got_b[ngot + b] = out_data[63 - 8*b -: 8];
                ngot += 32'(out_bytes);
                nbeats++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_elem(input int skip, input int len, input int mode,
                            input int seed, input string req);
        int errs;
        bp_mode = mode;
        for (int k = 0; k < len; k++) exp_b[k] = 8'(seed + 7*k);
        nwords = (skip + len + 7) / 8;
        for (int w = 0; w < nwords; w++) begin
            words[w] = '0;
            for (int b = 0; b < 8; b++) begin
                int p;
                logic [7:0] v;
                p = 8*w + b;
                v = (p < skip) ? 8'hEE : ((p < skip + len) ? exp_b[p - skip] : 8'hDD);
                words[w][63 - 8*b -: 8] = v;
            end
        end
        fork
            drive_words(skip, len);
            collect(skip, len);
        join
        check(ngot == len, req, "delivered byte total", ngot, len);
        errs = 0;
        for (int k = 0; k < len; k++) if (got_b[k] !== exp_b[k]) errs++;
        check(errs == 0, req, "byte order mismatches", errs, 0);
        check(got_b[0] == exp_b[0], "R2", "first delivered byte", got_b[0], exp_b[0]);
        if (skip + len <= 8)
            check(nbeats == 1, "R7", "single beat element", nbeats, 1);
        else
            check(nbeats == (len + 7) / 8, "R5", "beat count", nbeats, (len + 7) / 8);
        repeat (2) @(negedge clk);
        #2;
        check(!out_valid && in_ready, "R10", "idle after element",
              {out_valid, in_ready}, 2'b01);
    endtask

    task automatic t_unaligned();  run_elem(3, 13, 0, 8'h10, "R2"); endtask
    task automatic t_passthru();   run_elem(0, 24, 0, 8'h40, "R6"); endtask
    task automatic t_full_last();  run_elem(0, 8, 0, 8'h51, "R4"); endtask
    task automatic t_small();      run_elem(0, 5, 0, 8'h60, "R7"); endtask
    task automatic t_edge_skip();  run_elem(7, 1, 0, 8'h70, "R7"); endtask
    task automatic t_bp_alt();     run_elem(5, 20, 1, 8'h80, "R8"); endtask
    task automatic t_bp_slow();    run_elem(2, 30, 2, 8'h90, "R8"); endtask
    task automatic t_ctl_ignore(); run_elem(4, 17, 0, 8'hA0, "R9"); endtask
    task automatic t_long();       run_elem(6, 50, 1, 8'h05, "R5"); endtask

    initial begin
        t_reset();
        t_unaligned();
        t_passthru();
        t_full_last();
        t_small();
        t_edge_skip();
        t_bp_alt();
        t_bp_slow();
        t_ctl_ignore();
        t_long();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule